// File: doc/BRIEF.md
# Cross-Crate Energy Sum Trigger with Capture Window

This block forms a global energy sum from two per-clock streams and raises a trigger from it. On every clock it takes the energy sum produced in its own crate and the sum received from one neighbouring crate. It adds the two with saturation and registers the result. The registered global sum is compared against a programmable threshold. A single-cycle trigger pulse is issued on the cycle where the sum first moves above that threshold. Because the trigger fires on the edge and not on the level, each pulse in a burst produces its own trigger.

The block also keeps a circular history of the global sum in a memory that maps onto block RAM. When a trigger arrives and no capture is pending, the block sets up a window of `win_len` samples. `pre_len` of those samples come before the triggering sample. The block then keeps recording until the rest of the window has been stored, and freezes the history. It raises `capture_done` and waits for the window to be read out through a simple offset-addressed read port. Reading the last offset of the window releases the history so that it can be armed again.

Top module: `esum_trigger`

## Requirements
- R1: The global sum is `local_sum + remote_sum` when `remote_valid` is 1. When the true sum exceeds 2^32-1 it is held at 32'hFFFF_FFFF and does not wrap.
- R2: When `remote_valid` is 0, the remote term counts as zero whatever value `remote_sum` carries.
- R3: `trig_o` is high for exactly one cycle when a global sum is strictly greater than `threshold` and the sum before it was not. The pulse appears two clock edges after the inputs that formed that sum are sampled. A sum equal to the threshold does not fire.
- R4: While the sum stays above the threshold, no further trigger is issued. After the sum returns to or below the threshold, the next upward crossing fires again.
- R5: A captured window holds `win_len` consecutive global sums. Offset `pre_len` is the sum that caused the trigger, and offset 0 is the oldest sample. `rd_en` with `rd_off` places that sample on `rd_data` after one clock edge. `pre_len < win_len <= HIST_DEPTH` must hold, and HIST_DEPTH must be a power of two.
- R6: `capture_done` rises on the edge that stores the last sample of the window. It stays high until `rd_en` is applied with `rd_off = win_len-1`, and it is low after that edge.
- R7: A trigger that arrives while a capture is filling, or while `capture_done` is high, still pulses `trig_o`. It does not move or restart the window being held.
- R8: After reset, `trig_o` and `capture_done` are 0.
- R9: When `win_len = pre_len + 1`, the window ends at the triggering sample, and `capture_done` rises on the same edge as `trig_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one sum sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| local_sum | input | SUM_W | Energy sum from this crate |
| remote_sum | input | SUM_W | Energy sum from the neighbouring crate |
| remote_valid | input | 1 | Qualifies `remote_sum` |
| threshold | input | SUM_W | Trigger level; the sum must be strictly above it |
| pre_len | input | log2(HIST_DEPTH) | Window samples taken before the triggering sample |
| win_len | input | log2(HIST_DEPTH)+1 | Total window length in samples |
| rd_en | input | 1 | Read strobe for the captured window |
| rd_off | input | log2(HIST_DEPTH) | Offset into the window, 0 = oldest |
| trig_o | output | 1 | One-cycle trigger pulse |
| rd_data | output | SUM_W | Window sample, valid one cycle after `rd_en` |
| capture_done | output | 1 | A complete window is held and awaiting readout |

## Verification
Timing is counted from the clock edge that samples a set of inputs:
- The global sum is registered on that edge.
- The trigger for that sum is visible after the next edge.
- A read returns data after the edge that samples `rd_en`.
- `capture_done` appears after the edge that stores sample index trigger+`win_len`-`pre_len`-1.

The bench drives inputs and samples outputs on the falling edge. It keeps a per-sample model of the global sum and of the above-threshold flag. At each falling edge it compares `trig_o` against the model entry two samples back. It compares `capture_done` against the capture model state for the edge just passed, and compares `rd_data` against the model entry selected by the read issued one falling edge earlier. Every result is therefore checked in exactly the cycle it is due.

// File: rtl/esum_pkg.sv
package esum_pkg;
  // Capture controller states
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_POST = 1'b1
  } cap_st_e;
endpackage

// File: rtl/esum_adder.sv
module esum_adder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         b_valid_i,
  output logic [W-1:0] sum_q
);
  logic [W:0] wide;

  // Remote term is dropped when not valid; carry-out selects saturation
  assign wide = {1'b0, a_i} + {1'b0, (b_valid_i ? b_i : {W{1'b0}})};

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= wide[W] ? {W{1'b1}} : wide[W-1:0];
  end
endmodule

// File: rtl/esum_cross.sv
module esum_cross #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] thr_i,
  output logic         fire_o,
  output logic         trig_q
);
  logic above;
  logic above_q;

  assign above  = sum_i > thr_i;
  assign fire_o = above & ~above_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      above_q <= above;
      trig_q  <= fire_o;
    end
  end
endmodule

// File: rtl/esum_history.sv
module esum_history
  import esum_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din_i,
  input  logic          fire_i,
  input  logic [AW-1:0] pre_len_i,
  input  logic [LW-1:0] win_len_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_off_i,
  output logic [W-1:0]  rd_data_o,
  output logic          done_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] start_q;
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] post_len;
  logic [LW-1:0] cnt_q;
  logic          done_q;
  logic          last_rd;
  cap_st_e       st_q;

  assign post_len = win_len_i - {1'b0, pre_len_i} - LW'(1);
  assign rd_addr  = start_q + rd_off_i;
  assign last_rd  = rd_en_i && ({1'b0, rd_off_i} == win_len_i - LW'(1));
  assign done_o   = done_q;

  // Simple dual-port memory: one write, one registered read
  always_ff @(posedge clk) begin
    if (!done_q) mem[wr_ptr] <= din_i;
    if (rd_en_i) rd_data_o <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      st_q    <= CAP_IDLE;
    end else begin
      if (!done_q) wr_ptr <= wr_ptr + AW'(1);
      case (st_q)
        CAP_IDLE: begin
          if (fire_i && !done_q) begin
            start_q <= wr_ptr - pre_len_i;
            if (post_len == '0) begin
              done_q <= 1'b1;
            end else begin
              cnt_q <= post_len;
              st_q  <= CAP_POST;
            end
          end
        end
        CAP_POST: begin
          if (cnt_q == LW'(1)) begin
            done_q <= 1'b1;
            st_q   <= CAP_IDLE;
          end else begin
            cnt_q <= cnt_q - LW'(1);
          end
        end
        default: st_q <= CAP_IDLE;
      endcase
      if (done_q && last_rd) done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/esum_trigger.sv
module esum_trigger #(
  parameter int SUM_W      = 32,
  parameter int HIST_DEPTH = 512,
  localparam int AW        = $clog2(HIST_DEPTH),
  localparam int LW        = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] local_sum,
  input  logic [SUM_W-1:0] remote_sum,
  input  logic             remote_valid,
  input  logic [SUM_W-1:0] threshold,
  input  logic [AW-1:0]    pre_len,
  input  logic [LW-1:0]    win_len,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_off,
  output logic             trig_o,
  output logic [SUM_W-1:0] rd_data,
  output logic             capture_done
);
  logic [SUM_W-1:0] gsum;
  logic             fire;

  esum_adder #(.W(SUM_W)) u_add (
    .clk(clk), .rst(rst),
    .a_i(local_sum), .b_i(remote_sum), .b_valid_i(remote_valid),
    .sum_q(gsum)
  );

  esum_cross #(.W(SUM_W)) u_cross (
    .clk(clk), .rst(rst),
    .sum_i(gsum), .thr_i(threshold),
    .fire_o(fire), .trig_q(trig_o)
  );

  esum_history #(.W(SUM_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst(rst),
    .din_i(gsum), .fire_i(fire),
    .pre_len_i(pre_len), .win_len_i(win_len),
    .rd_en_i(rd_en), .rd_off_i(rd_off),
    .rd_data_o(rd_data), .done_o(capture_done)
  );
endmodule

// File: rtl/esum_trigger_chk.sv
module esum_trigger_chk #(
  parameter int SUM_W      = 32,
  parameter int HIST_DEPTH = 512,
  localparam int AW        = $clog2(HIST_DEPTH),
  localparam int LW        = AW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [SUM_W-1:0] local_sum,
  input logic [SUM_W-1:0] remote_sum,
  input logic             remote_valid,
  input logic [SUM_W-1:0] threshold,
  input logic [LW-1:0]    win_len,
  input logic             rd_en,
  input logic [AW-1:0]    rd_off,
  input logic             trig_o,
  input logic             capture_done
);
  function automatic logic [SUM_W-1:0] sat_sum(input logic [SUM_W-1:0] a,
                                               input logic [SUM_W-1:0] b,
                                               input logic v);
    logic [SUM_W:0] t;
    t = {1'b0, a} + (v ? {1'b0, b} : '0);
    return t[SUM_W] ? {SUM_W{1'b1}} : t[SUM_W-1:0];
  endfunction

  logic last_rd;
  assign last_rd = rd_en && ({1'b0, rd_off} == win_len - LW'(1));

  // R3: the trigger is a single-cycle pulse
  p_trig_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);

  // R1, R2, R3: a trigger implies the input pair two edges back summed above the threshold
  p_trig_above_r1: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> (sat_sum($past(local_sum, 2), $past(remote_sum, 2),
                        $past(remote_valid, 2)) > $past(threshold)));

  // R6: done holds until the last offset is read
  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (capture_done && !last_rd) |=> capture_done);

  // R6: reading the last offset releases the capture
  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (capture_done && last_rd) |=> !capture_done);
endmodule

bind esum_trigger esum_trigger_chk #(.SUM_W(SUM_W), .HIST_DEPTH(HIST_DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .local_sum(local_sum), .remote_sum(remote_sum), .remote_valid(remote_valid),
  .threshold(threshold), .win_len(win_len),
  .rd_en(rd_en), .rd_off(rd_off),
  .trig_o(trig_o), .capture_done(capture_done)
);

// File: tb/tb_esum_trigger.sv
module tb_esum_trigger;
  localparam int W  = 32;
  localparam int D  = 512;
  localparam int AW = 9;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  local_sum = '0, remote_sum = '0, threshold = '0;
  logic          remote_valid = 1'b0;
  logic [AW-1:0] pre_len = '0;
  logic [LW-1:0] win_len = LW'(1);
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_off = '0;
  logic          trig_o;
  logic [W-1:0]  rd_data;
  logic          capture_done;

  esum_trigger #(.SUM_W(W), .HIST_DEPTH(D)) dut (
    .clk(clk), .rst(rst), .local_sum(local_sum), .remote_sum(remote_sum),
    .remote_valid(remote_valid), .threshold(threshold), .pre_len(pre_len),
    .win_len(win_len), .rd_en(rd_en), .rd_off(rd_off), .trig_o(trig_o),
    .rd_data(rd_data), .capture_done(capture_done)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [W-1:0] gs [0:4095];
  logic         ab [0:4095];
  int    n = 1;
  int    cap_t = -1;
  bit    clr_pend = 0, rd_pend = 0;
  int    rd_idx = 0;
  int    trig_cnt = 0;
  bit    done_at_trig = 0;
  string cur_tag = "R5";
  bit    finished = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (sample %0d)", tag, act, exp, n);
    end
  endtask

  function automatic logic [W-1:0] sat(logic [W-1:0] a, logic [W-1:0] b, logic v);
    logic [W:0] t;
    t = {1'b0, a} + (v ? {1'b0, b} : '0);
    return t[W] ? {W{1'b1}} : t[W-1:0];
  endfunction

  // One sample per call: check outputs due now, then drive the next inputs
  task automatic step(logic [W-1:0] l, logic [W-1:0] r, logic v,
                      logic re, logic [AW-1:0] ro);
    int  s;
    bit  et, ed;
    int  post;
    @(negedge clk);
    post = int'(win_len) - int'(pre_len) - 1;
    s  = n - 2;
    et = (s >= 0) && ab[s] && !((s >= 1) && ab[s-1]);
    if (et && cap_t < 0) cap_t = s;
    if (clr_pend) begin cap_t = -1; clr_pend = 0; end
    ed = (cap_t >= 0) && (n >= cap_t + post + 2);
    chk("R3", {31'b0, trig_o}, {31'b0, et});
    chk(cur_tag, {31'b0, capture_done}, {31'b0, ed});
    if (trig_o) begin trig_cnt++; done_at_trig = capture_done; end
    if (rd_pend) begin
      chk(cur_tag, rd_data, gs[rd_idx]);
      rd_pend = 0;
    end
    local_sum = l; remote_sum = r; remote_valid = v;
    rd_en = re; rd_off = ro;
    gs[n] = sat(l, r, v);
    ab[n] = gs[n] > threshold;
    if (re) begin
      rd_pend = 1;
      rd_idx  = cap_t - int'(pre_len) + int'(ro);
      if (ed && (int'(ro) == int'(win_len) - 1)) clr_pend = 1;
    end
    n++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step('0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic readout();
    for (int o = 0; o < int'(win_len); o++) step('0, '0, 1'b0, 1'b1, AW'(o));
    idle(2);
    chk("R6", {31'b0, capture_done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R8", {31'b0, trig_o}, 32'd0);
    chk("R8", {31'b0, capture_done}, 32'd0);
  endtask

  task automatic t_basic();
    logic [W-1:0] lv [10] = '{10, 20, 30, 40, 600, 900, 700, 300, 5, 5};
    threshold = 1000; pre_len = 3; win_len = 8; cur_tag = "R5";
    idle(4);
    trig_cnt = 0;
    for (int i = 0; i < 10; i++) step(lv[i], 200, 1'b1, 1'b0, '0);
    idle(6);
    chk("R1", trig_cnt, 1);
    chk("R6", {31'b0, capture_done}, 32'd1);
    readout();
  endtask

  task automatic t_remote_ignored();
    cur_tag = "R2"; idle(6);
    trig_cnt = 0;
    for (int i = 0; i < 4; i++) step(900, 5000, 1'b0, 1'b0, '0);
    chk("R2", trig_cnt, 0);
    step(0, 5000, 1'b0, 1'b0, '0);
    step(1001, 5000, 1'b0, 1'b0, '0);
    for (int i = 0; i < 4; i++) step(i, 5000, 1'b0, 1'b0, '0);
    idle(4);
    chk("R2", trig_cnt, 1);
    readout();
  endtask

  task automatic t_rearm();
    logic [W-1:0] lv [10] = '{1500, 1500, 1500, 1500, 0, 0, 1500, 1000, 2000, 0};
    cur_tag = "R7"; idle(6);
    trig_cnt = 0;
    for (int i = 0; i < 10; i++) step(lv[i], 0, 1'b0, 1'b0, '0);
    idle(4);
    chk("R4", trig_cnt, 3);
    chk("R7", {31'b0, capture_done}, 32'd1);
    readout();
  endtask

  task automatic t_saturate();
    cur_tag = "R1"; idle(4);
    threshold = 32'hFFFF_FFFE; idle(4);
    trig_cnt = 0;
    step(32'hFFFF_FFF0, 32'h0000_0100, 1'b1, 1'b0, '0);
    step(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, '0);
    idle(8);
    chk("R1", trig_cnt, 1);
    readout();
    threshold = 1000; idle(4);
  endtask

  task automatic t_post_zero();
    cur_tag = "R9"; pre_len = 3; win_len = 4; idle(6);
    trig_cnt = 0; done_at_trig = 0;
    step(100, 1200, 1'b1, 1'b0, '0);
    idle(4);
    chk("R9", trig_cnt, 1);
    chk("R9", {31'b0, done_at_trig}, 32'd1);
    readout();
  endtask

  task automatic t_long();
    cur_tag = "R5"; pre_len = 100; win_len = 500; idle(4);
    trig_cnt = 0;
    for (int i = 0; i < 120; i++) step(W'(i * 3), W'(i), 1'b1, 1'b0, '0);
    step(1400, 0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 420; i++) step(W'(i), 0, 1'b0, 1'b0, '0);
    chk("R5", trig_cnt, 1);
    chk("R6", {31'b0, capture_done}, 32'd1);
    readout();
  endtask

  initial begin
    gs[0] = '0; ab[0] = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_basic();
    t_remote_ignored();
    t_rearm();
    t_saturate();
    t_post_zero();
    t_long();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule